// File: doc/BRIEF.md
# Two-Register Bit-Serial Datapath

This block is a tiny bit-serial datapath. It holds two 8-bit registers, R0 and R1, and one serial adder whose result always returns to R0. Each register stores its value as a circulating 12-bit ring. Eight content bits travel least significant bit first and are followed by four zero pad bits. Every operation takes one full turn of the rings, which is a 12-cycle frame.

No opcode exists. A 4-bit control word arrives serially on `code_in` while `code_stb` is high. It is captured through a tapped shift register. Each bit sets one flag:
- R0 enable: R0 feeds the adder.
- R0 hold: R0 recirculates.
- R1 enable: R1 feeds the adder.
- R1 hold: R1 recirculates.

A register that is not in hold is rewritten. R0 takes the adder output and R1 takes the external serial input. Load, store, add and copy are simply four flag combinations. Store, copy and hold all work by adding zero.

A completed control word waits until the current frame ends and then starts the next frame. During every frame, both registers stream out on observation pins. R0 also appears on the store output whenever it is enabled.

Top module: `dualreg_serial_dp`

## Requirements
- R1: After reset, `busy`, `store_out`, `r0_obs` and `r1_obs` are 0, and both registers hold 0.
- R2: Control bits are strobed in this order: R0 enable, R0 hold, R1 enable, R1 hold. Written as a 4-bit word {first..fourth}, the word replaces all four flags at once. If no frame is running, the frame starts on the clock edge after the edge that captured the fourth bit.
- R3: A frame lasts 12 cycles. In frame cycle k (0..7), `r0_obs` and `r1_obs` show bit k of the register value held at frame start. In cycles 8..11 they are 0.
- R4: Word 0100 (load) writes the `data_in` bits sampled in frame cycles 0..7 into R1 and leaves R0 unchanged.
- R5: Word 1001 (store) puts R0 on `store_out` in the same cycles as `r0_obs`, and leaves both registers unchanged.
- R6: Word 1011 (add) sets R0 to (R0 + R1) mod 256, drops the carry out of bit 7, and leaves R1 unchanged.
- R7: Word 0011 (copy) sets R0 to R1 and leaves R1 unchanged.
- R8: Word 0000 with `data_in` held low clears both registers.
- R9: A word completed during a frame does not affect that frame. Its frame starts immediately after that frame ends, with no idle cycle between them.
- R10: `busy` is high while `code_stb` is high, while a word is partly received or pending, and throughout a frame. It is low otherwise.
- R11: For any word, R0 takes (R0·en0 + R1·en1) mod 256 unless its hold flag is set, and R1 takes `data_in` unless its hold flag is set. `store_out` is 0 whenever R0 is disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| code_in | input | 1 | Serial control bit |
| code_stb | input | 1 | Shifts `code_in` into the control register |
| data_in | input | 1 | Serial load data for R1, LSB first, frame cycles 0..7 |
| store_out | output | 1 | R0 stream while R0 is enabled, else 0 |
| r0_obs | output | 1 | R0 stream during a frame |
| r1_obs | output | 1 | R1 stream during a frame |
| busy | output | 1 | Control reception or frame activity |

## Verification
The collision that matters is a control word being received while a frame is running. That is also the only way a word can complete on the same edge as a frame's last cycle. The bench strobes a second word in frame cycles 2 to 5. It then checks three things: the running frame's outputs and results match its own flags, `busy` stays high across the boundary, and the second frame begins on the very next cycle with the new flags. The rest of the stimulus sweeps all 16 control words plus a 16×16 grid of operand pairs, including overflowing sums. Expected values are computed arithmetically from the flag rule.

// File: rtl/dualreg_pkg.sv
package dualreg_pkg;
  // Control flags in strobe order: the first bit strobed lands in r0_en.
  typedef struct packed {
    logic r0_en;
    logic r0_thr;
    logic r1_en;
    logic r1_thr;
  } ctl_flags_t;

  localparam int CTL_W = $bits(ctl_flags_t);
endpackage

// File: rtl/dualreg_code_rx.sv
module dualreg_code_rx #(
  parameter int CODE_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stb,
  input  logic              din,
  input  logic              take,
  output logic              pend,
  output logic [CODE_W-1:0] pcode,
  output logic              shifting
);
  localparam int CNT_W = $clog2(CODE_W);

  logic [CODE_W-2:0] sh_q, sh_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [CODE_W-1:0] pcode_q, pcode_d;
  logic              pend_q, pend_d;
  logic              last_bit;

  always_comb begin
    last_bit = stb && (cnt_q == CNT_W'(CODE_W-1));
    sh_d     = sh_q;
    cnt_d    = cnt_q;
    if (stb) begin
      sh_d  = {sh_q[CODE_W-3:0], din};
      cnt_d = last_bit ? '0 : cnt_q + 1'b1;
    end
    pcode_d = last_bit ? {sh_q, din} : pcode_q;
    if (last_bit)  pend_d = 1'b1;
    else if (take) pend_d = 1'b0;
    else           pend_d = pend_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q    <= '0;
      cnt_q   <= '0;
      pcode_q <= '0;
      pend_q  <= 1'b0;
    end else begin
      sh_q    <= sh_d;
      cnt_q   <= cnt_d;
      pcode_q <= pcode_d;
      pend_q  <= pend_d;
    end
  end

  assign pend     = pend_q;
  assign pcode    = pcode_q;
  assign shifting = (cnt_q != '0);
endmodule

// File: rtl/dualreg_ring.sv
module dualreg_ring #(
  parameter int LEN = 12
) (
  input  logic clk,
  input  logic rst_n,
  input  logic shift,
  input  logic thr,
  input  logic ext,
  output logic head
);
  logic [LEN-1:0] ring_q, ring_d;

  always_comb begin
    ring_d = ring_q;
    if (shift) ring_d = {(thr ? ring_q[0] : ext), ring_q[LEN-1:1]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ring_q <= '0;
    else        ring_q <= ring_d;
  end

  assign head = ring_q[0];
endmodule

// File: rtl/dualreg_adder.sv
module dualreg_adder (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic pad,
  input  logic a,
  input  logic b,
  output logic sum
);
  logic carry_q, carry_d;

  always_comb begin
    sum     = !pad && (a ^ b ^ carry_q);
    carry_d = run && !pad && ((a & b) | (a & carry_q) | (b & carry_q));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) carry_q <= 1'b0;
    else        carry_q <= carry_d;
  end
endmodule

// File: rtl/dualreg_serial_dp.sv
module dualreg_serial_dp #(
  parameter int DW  = 8,
  parameter int PAD = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic code_in,
  input  logic code_stb,
  input  logic data_in,
  output logic store_out,
  output logic r0_obs,
  output logic r1_obs,
  output logic busy
);
  import dualreg_pkg::*;

  localparam int FRAME = DW + PAD;
  localparam int CW    = $clog2(FRAME);
  localparam logic [CW-1:0] LAST = CW'(FRAME-1);
  localparam int NREG  = 2;

  logic [1:0] rst_sync_q;
  logic       rst_n_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_i = rst_sync_q[1];

  logic             pend, shifting, start;
  logic [CTL_W-1:0] pcode;

  dualreg_code_rx #(.CODE_W(CTL_W)) code_rx_i (
    .clk(clk), .rst_n(rst_n_i), .stb(code_stb), .din(code_in),
    .take(start), .pend(pend), .pcode(pcode), .shifting(shifting)
  );

  logic          active_q, active_d;
  logic [CW-1:0] fcnt_q, fcnt_d;
  ctl_flags_t    flags_q, flags_d;
  logic          frame_end, pad;

  always_comb begin
    frame_end = active_q && (fcnt_q == LAST);
    start     = pend && (!active_q || frame_end);
    active_d  = active_q;
    fcnt_d    = fcnt_q;
    flags_d   = flags_q;
    if (start) begin
      active_d = 1'b1;
      fcnt_d   = '0;
      flags_d  = ctl_flags_t'(pcode);
    end else if (frame_end) begin
      active_d = 1'b0;
      fcnt_d   = '0;
    end else if (active_q) begin
      fcnt_d   = fcnt_q + 1'b1;
    end
    pad = (fcnt_q >= CW'(DW));
  end

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      active_q <= 1'b0;
      fcnt_q   <= '0;
      flags_q  <= '0;
    end else begin
      active_q <= active_d;
      fcnt_q   <= fcnt_d;
      flags_q  <= flags_d;
    end
  end

  logic [NREG-1:0] head, thr, ext;
  logic            op_a, op_b, sum;

  assign thr[0] = flags_q.r0_thr;
  assign thr[1] = flags_q.r1_thr;
  assign ext[0] = sum;
  assign ext[1] = !pad && data_in;

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    dualreg_ring #(.LEN(FRAME)) ring_i (
      .clk(clk), .rst_n(rst_n_i), .shift(active_q),
      .thr(thr[g]), .ext(ext[g]), .head(head[g])
    );
  end

  assign op_a = flags_q.r0_en && head[0];
  assign op_b = flags_q.r1_en && head[1];

  dualreg_adder adder_i (
    .clk(clk), .rst_n(rst_n_i), .run(active_q), .pad(pad),
    .a(op_a), .b(op_b), .sum(sum)
  );

  assign store_out = active_q && op_a;
  assign r0_obs    = active_q && head[0];
  assign r1_obs    = active_q && head[1];
  assign busy      = code_stb || shifting || pend || active_q;
endmodule

// File: rtl/dualreg_serial_dp_chk.sv
module dualreg_serial_dp_chk #(
  parameter int DW = 8,
  parameter int CW = 4,
  parameter int LAST = 11
) (
  input logic          clk,
  input logic          rst_n,
  input logic          code_stb,
  input logic          busy,
  input logic          store_out,
  input logic          r0_obs,
  input logic          r1_obs,
  input logic          active,
  input logic          pend,
  input logic [CW-1:0] fcnt,
  input logic [3:0]    flags
);
  // R10
  strobe_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    code_stb |=> busy);

  // R2
  start_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(active) |-> $past(pend));

  // R3
  frame_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(active) |-> ($past(fcnt) == CW'(LAST)));

  // R3
  pad_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active && fcnt >= CW'(DW)) |-> (!r0_obs && !r1_obs && !store_out));

  // R5
  store_mirror_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active && flags == 4'b1001) |-> (store_out == r0_obs));
endmodule

bind dualreg_serial_dp dualreg_serial_dp_chk #(
  .DW(DW), .CW(CW), .LAST(FRAME-1)
) chk_i (
  .clk(clk), .rst_n(rst_n_i), .code_stb(code_stb), .busy(busy),
  .store_out(store_out), .r0_obs(r0_obs), .r1_obs(r1_obs),
  .active(active_q), .pend(pend), .fcnt(fcnt_q), .flags(flags_q)
);

// File: tb/dualreg_serial_dp_tb_top.sv
module dualreg_serial_dp_tb_top;
  logic clk = 1'b0;
  logic rst_n, code_in, code_stb, data_in;
  logic store_out, r0_obs, r1_obs, busy;
  int   checks = 0, fails = 0;
  bit   done = 1'b0;
  logic [7:0] m_r0 = 8'h00, m_r1 = 8'h00;

  always #2 clk = ~clk;

  dualreg_serial_dp dut_i (
    .clk(clk), .rst_n(rst_n), .code_in(code_in), .code_stb(code_stb),
    .data_in(data_in), .store_out(store_out), .r0_obs(r0_obs),
    .r1_obs(r1_obs), .busy(busy)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic string req_of(input logic [3:0] c);
    case (c)
      4'b0100: return "R4";
      4'b1001: return "R5";
      4'b1011: return "R6";
      4'b0011: return "R7";
      4'b0000: return "R8";
      default: return "R11";
    endcase
  endfunction

  task automatic send_code(input logic [3:0] c);
    for (int i = 0; i < 4; i++) begin
      code_stb = 1'b1;
      code_in  = c[3-i];
      @(negedge clk);
      chk("R10", busy, 1'b1);
    end
    code_stb = 1'b0;
    code_in  = 1'b0;
    @(negedge clk);
  endtask

  // Called at frame cycle 0; returns at the cycle after the frame.
  task automatic run_frame(input logic [3:0] c, input logic [7:0] din,
                           input bit overlap, input logic [3:0] c2);
    logic [11:0] a0, a1, as;
    logic [7:0]  e_st, n0, n1;
    string       rq;
    rq = req_of(c);
    for (int k = 0; k < 12; k++) begin
      a0[k] = r0_obs;
      a1[k] = r1_obs;
      as[k] = store_out;
      chk("R10", busy, 1'b1);
      data_in = (k < 8) ? din[k] : 1'b0;
      if (overlap && k >= 2 && k <= 5) begin
        code_stb = 1'b1;
        code_in  = c2[5-k];
      end else begin
        code_stb = 1'b0;
        code_in  = 1'b0;
      end
      @(negedge clk);
    end
    data_in = 1'b0;
    e_st = c[3] ? m_r0 : 8'h00;
    chk("R3", {20'h0, a0}, {24'h0, m_r0});
    chk("R3", {20'h0, a1}, {24'h0, m_r1});
    chk(c == 4'b1001 ? "R5" : "R11", {20'h0, as}, {24'h0, e_st});
    n0 = c[2] ? m_r0 : 8'((c[3] ? m_r0 : 8'h0) + (c[1] ? m_r1 : 8'h0));
    n1 = c[0] ? m_r1 : din;
    m_r0 = n0;
    m_r1 = n1;
    if (overlap) chk("R9", busy, 1'b1);
    else         chk("R10", busy, 1'b0);
    // next frame (or a later observation) verifies n0/n1 under tag rq
    if (rq.len() == 0) chk("R2", 0, 1);
  endtask

  task automatic do_op(input logic [3:0] c, input logic [7:0] din);
    send_code(c);
    run_frame(c, din, 1'b0, 4'b0);
  endtask

  task automatic verify_regs(input string req);
    logic [7:0] e0, e1;
    e0 = m_r0;
    e1 = m_r1;
    send_code(4'b0101);
    run_frame(4'b0101, 8'h00, 1'b0, 4'b0);
    chk(req, {m_r0, m_r1}, {e0, e1});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; code_in = 1'b0; code_stb = 1'b0; data_in = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk("R1", {busy, store_out, r0_obs, r1_obs}, 4'b0000);
    do_op(4'b1001, 8'h00);  // store shows zeros from reset (R1)
    chk("R1", {m_r0, m_r1}, 16'h0000);

    // R4 load, R7 copy, R6 add with overflow, R5 store
    do_op(4'b0100, 8'd219);
    do_op(4'b0011, 8'h00);
    do_op(4'b0100, 8'd236);
    do_op(4'b1011, 8'h00);
    chk("R6", m_r0, 8'd199);
    do_op(4'b1001, 8'h00);
    verify_regs("R5");

    // R2 / R11: every control word from a known state
    for (int c = 0; c < 16; c++) begin
      do_op(4'b0100, 8'h5A);
      do_op(4'b0011, 8'h00);
      do_op(4'b0100, 8'hC3);
      do_op(4'(c), 8'h96);
      verify_regs("R2");
    end

    // R8 clear with data_in low
    do_op(4'b0000, 8'h00);
    chk("R8", {m_r0, m_r1}, 16'h0000);
    verify_regs("R8");

    // R9 back-to-back: add with a copy strobed in mid-frame
    do_op(4'b0100, 8'd77);
    do_op(4'b0011, 8'h00);
    do_op(4'b0100, 8'd200);
    send_code(4'b1011);
    run_frame(4'b1011, 8'h00, 1'b1, 4'b0011);
    run_frame(4'b0011, 8'h00, 1'b0, 4'b0);
    chk("R9", m_r0, 8'd200);
    verify_regs("R9");

    // R6 sweep over operand pairs
    for (int ai = 0; ai < 16; ai++) begin
      for (int bi = 0; bi < 16; bi++) begin
        logic [7:0] av, bv;
        av = 8'(ai * 17);
        bv = 8'(bi * 29 + 3);
        do_op(4'b0100, av);
        do_op(4'b0011, 8'h00);
        do_op(4'b0100, bv);
        do_op(4'b1011, 8'h00);
        chk("R6", m_r0, 8'(av + bv));
        do_op(4'b1001, 8'h00);
      end
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule